// File: doc/BRIEF.md
# SPI Status Flag and Interrupt Unit

This unit holds the four status flags of a serial peripheral interface port that can work as master or slave, and turns them into two CPU interrupt lines. The flags are transmit-empty, receive-full, overflow and mode-fault. The transmit line is driven by transmit-empty alone. The second line is shared by the receiver and the two error conditions, and each source on it has its own set of enable conditions.

The shift register and the baud generator are not part of this unit. They appear only as single-cycle event inputs: a byte moved into the shifter, a byte completed, and a level that reports a mode-fault condition. The unit also applies the slave-select rules to the slave data output and to the incoming serial clock. It exposes three registers to the CPU (control, status and data), and each has its own read and write strobes. Mode-fault clears only through a two-step sequence: a status read, then a control write. Overflow clears through a status read followed by a data read.

Top module: `spi_flag_irq_unit`

## Requirements
- R1: After reset the control readback is 0x00 and the status readback is 0x01, with bit 0 = transmit-empty, bit 1 = receive-full, bit 2 = overflow and bit 3 = mode-fault. Both interrupt lines are low.
- R2: A data write clears transmit-empty and a shifter-load event sets it. Control bit 2 is the transmit interrupt enable, and `irq_tx` equals transmit-empty AND that enable.
- R3: A completion event while receive-full is set and no data read occurs in the same cycle sets overflow and keeps receive-full. It also holds `rx_buf_we` low, so the byte already held is kept. Any other completion pulses `rx_buf_we`.
- R4: Overflow clears only on a data read that follows a status read which saw overflow set. A data read without that status read leaves overflow set.
- R5: Receive-full drives `irq_rx` only when control bit 3 (receive interrupt enable) and control bit 0 (module enable) are both set.
- R6: Overflow drives `irq_rx` only when control bit 3 and control bit 4 (error interrupt enable) are both set.
- R7: Mode-fault drives `irq_rx` only when control bits 3, 4 and 5 (mode-fault detection enable) are all set.
- R8: `modf_cond` sets mode-fault while the module is enabled. Setting mode-fault leaves control bit 0 unchanged.
- R9: Mode-fault clears on a control write that follows a status read which saw it set. A control write with no such preceding read leaves it set.
- R10: If `modf_cond` is active at any time during the clear sequence, the flag stays set.
- R11: In slave mode (bit 0 = 1, bit 1 = 0) with `ss_n_in` high, `miso_oe` is low and `sck_gated` is low whatever `sck_in` does. With `ss_n_in` low, the clock passes through and MISO is driven. A master passes the clock through regardless of `ss_n_in`.
- R12: Both interrupt lines are registered and follow a flag change one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wdata | input | 8 | CPU write data |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_rd | input | 1 | Control register read strobe |
| stat_rd | input | 1 | Status register read strobe |
| data_wr | input | 1 | Transmit data write strobe |
| data_rd | input | 1 | Receive data read strobe |
| ctrl_rdata | output | 8 | Control register readback |
| stat_rdata | output | 8 | Status register readback |
| tx_load_evt | input | 1 | Shifter took the transmit byte |
| rx_done_evt | input | 1 | Shifter completed a byte |
| modf_cond | input | 1 | Mode-fault condition level |
| rx_buf_we | output | 1 | Load completed byte into receive buffer |
| ss_n_in | input | 1 | Slave select, active low |
| sck_in | input | 1 | Incoming serial clock |
| miso_drive_in | input | 1 | Slave data bit from shifter |
| sck_gated | output | 1 | Serial clock passed to shifter |
| miso_out | output | 1 | Slave data output value |
| miso_oe | output | 1 | Slave data output enable |
| irq_tx | output | 1 | Transmitter interrupt |
| irq_rx | output | 1 | Receiver/error interrupt |

## Verification
The bench drives the interrupt gating through a table of control values and flag setups. In that table, each enable is missing from exactly one entry. A design that left out the module-enable term, or dropped a term from the mode-fault product, would raise `irq_rx` where it must stay low. The bench breaks the mode-fault clear sequence in three ways: a fault that appears between the read and the write, a control write with no status read before it, and the complete sequence. A design that cleared on any control write, or that ignored a fault arriving mid-sequence, would drop the flag too early. The bench also checks that a second completion leaves the held byte untouched, that a data read alone leaves overflow set, and that a deselected slave cuts off both the clock and the output enable while a master keeps its clock.

// File: rtl/spi_flag_pkg.sv
// Package: shared control-register layout for the SPI flag/interrupt unit.
// Assumes: REG_W >= 8 so every field fits in the CPU data width.
package spi_flag_pkg;

    localparam int REG_W   = 8;
    localparam int CTRL_W  = 6;
    localparam int STAT_W  = 4;

    // Control register, bit 0 is module enable (packed: last field is LSB).
    typedef struct packed {
        logic modf_en;   // bit 5: mode-fault detection enable
        logic err_ie;    // bit 4: error interrupt enable
        logic rx_ie;     // bit 3: receive interrupt enable
        logic tx_ie;     // bit 2: transmit interrupt enable
        logic master;    // bit 1: master mode
        logic mod_en;    // bit 0: module enable
    } ctrl_t;

    // Status flag bundle, bit 0 is transmit-empty.
    typedef struct packed {
        logic modf;      // bit 3
        logic ovr;       // bit 2
        logic rx_full;   // bit 1
        logic tx_empty;  // bit 0
    } stat_t;

endpackage

// File: rtl/spi_ctrl_reg.sv
// Module: control register of the SPI flag unit.
// Holds the enable and mode bits written by the CPU; reads back zero-padded.
// Assumes: write strobe is a single-cycle pulse, data valid with it.
module spi_ctrl_reg
    import spi_flag_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl,
    output logic [DW-1:0] rdata
);
    localparam int PAD_W = DW - CTRL_W;

    // Capture the control fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    // Zero-extend the control fields for readback.
    always_comb begin
        rdata = {{PAD_W{1'b0}}, ctrl};
    end

endmodule

// File: rtl/spi_status_flags.sv
// Module: status flags and their set/clear sequencing.
// Transmit-empty, receive-full, overflow and mode-fault. Overflow and
// mode-fault each need a status read that saw the flag set before the
// clearing access; a mode-fault seen during the sequence blocks the clear.
// Assumes: event inputs are single-cycle pulses from the shifter side.
module spi_status_flags
    import spi_flag_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mod_en,
    input  logic          stat_rd,
    input  logic          ctrl_wr,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic          tx_load_evt,
    input  logic          rx_done_evt,
    input  logic          modf_cond,
    output stat_t         flags,
    output logic          rx_buf_we,
    output logic [DW-1:0] rdata
);
    localparam int PAD_W = DW - STAT_W;

    logic ovr_armed;
    logic modf_armed;
    logic modf_clean;
    logic full_hit;
    logic modf_set;
    logic modf_clear;
    logic ovr_clear;

    // Decode this cycle's set and clear conditions.
    always_comb begin
        full_hit   = rx_done_evt & flags.rx_full & ~data_rd;
        modf_set   = modf_cond & mod_en;
        modf_clear = ctrl_wr & modf_armed & modf_clean & ~modf_cond;
        ovr_clear  = data_rd & ovr_armed;
        rx_buf_we  = rx_done_evt & ~full_hit;
    end

    // Transmit-empty: load event sets, data write clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags.tx_empty <= 1'b1;
        end else if (tx_load_evt) begin
            flags.tx_empty <= 1'b1;
        end else if (data_wr) begin
            flags.tx_empty <= 1'b0;
        end
    end

    // Receive-full: completion sets, data read clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags.rx_full <= 1'b0;
        end else if (rx_done_evt) begin
            flags.rx_full <= 1'b1;
        end else if (data_rd) begin
            flags.rx_full <= 1'b0;
        end
    end

    // Overflow flag: completion into a full buffer sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags.ovr <= 1'b0;
        end else if (full_hit) begin
            flags.ovr <= 1'b1;
        end else if (ovr_clear) begin
            flags.ovr <= 1'b0;
        end
    end

    // Overflow clear arming: a status read arms, a data read consumes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_armed <= 1'b0;
        end else if (stat_rd) begin
            ovr_armed <= flags.ovr;
        end else if (data_rd) begin
            ovr_armed <= 1'b0;
        end
    end

    // Mode-fault flag: fault condition sets, completed clean sequence clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags.modf <= 1'b0;
        end else if (modf_set) begin
            flags.modf <= 1'b1;
        end else if (modf_clear) begin
            flags.modf <= 1'b0;
        end
    end

    // Mode-fault clear arming: status read restarts, control write consumes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            modf_armed <= 1'b0;
        end else if (stat_rd) begin
            modf_armed <= flags.modf;
        end else if (ctrl_wr) begin
            modf_armed <= 1'b0;
        end
    end

    // Track whether a fault condition appeared since the arming read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            modf_clean <= 1'b0;
        end else if (stat_rd) begin
            modf_clean <= ~modf_cond;
        end else if (modf_cond) begin
            modf_clean <= 1'b0;
        end
    end

    // Zero-extend the flags for readback.
    always_comb begin
        rdata = {{PAD_W{1'b0}}, flags};
    end

endmodule

// File: rtl/spi_irq_gen.sv
// Module: interrupt request generation.
// Gates the flags with the enables and registers both request lines.
// Assumes: flags and enables come from registers in the same clock domain.
module spi_irq_gen
    import spi_flag_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    input  stat_t flags,
    output logic  irq_tx,
    output logic  irq_rx
);
    logic tx_req;
    logic rxf_req;
    logic ovr_req;
    logic modf_req;

    // Combine each flag with the enables it needs.
    always_comb begin
        tx_req   = flags.tx_empty & ctrl.tx_ie;
        rxf_req  = flags.rx_full & ctrl.rx_ie & ctrl.mod_en;
        ovr_req  = flags.ovr & ctrl.rx_ie & ctrl.err_ie;
        modf_req = flags.modf & ctrl.rx_ie & ctrl.err_ie & ctrl.modf_en;
    end

    // Register the two request lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_tx <= 1'b0;
            irq_rx <= 1'b0;
        end else begin
            irq_tx <= tx_req;
            irq_rx <= rxf_req | ovr_req | modf_req;
        end
    end

endmodule

// File: rtl/spi_slave_gate.sv
// Module: slave-select gating of the serial clock and slave data output.
// A deselected slave drives no data and passes no clock to the shifter.
// Assumes: the pad logic applies miso_oe to build the tri-state output.
module spi_slave_gate
    import spi_flag_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  ss_n_in,
    input  logic  sck_in,
    input  logic  miso_drive_in,
    output logic  sck_gated,
    output logic  miso_out,
    output logic  miso_oe
);
    logic is_slave;
    logic slave_off;

    // Decide whether the slave is deselected, then gate clock and output.
    always_comb begin
        is_slave  = ctrl.mod_en & ~ctrl.master;
        slave_off = is_slave & ss_n_in;
        sck_gated = sck_in & ~slave_off;
        miso_oe   = is_slave & ~ss_n_in;
        miso_out  = miso_drive_in & miso_oe;
    end

endmodule

// File: rtl/spi_flag_irq_unit.sv
// Module: top of the SPI status flag and interrupt unit.
// Connects control register, status flags, interrupt generation and
// slave-select gating. Assumes single clock domain, synchronous reset.
module spi_flag_irq_unit
    import spi_flag_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] reg_wdata,
    input  logic          ctrl_wr,
    input  logic          ctrl_rd,
    input  logic          stat_rd,
    input  logic          data_wr,
    input  logic          data_rd,
    output logic [DW-1:0] ctrl_rdata,
    output logic [DW-1:0] stat_rdata,
    input  logic          tx_load_evt,
    input  logic          rx_done_evt,
    input  logic          modf_cond,
    output logic          rx_buf_we,
    input  logic          ss_n_in,
    input  logic          sck_in,
    input  logic          miso_drive_in,
    output logic          sck_gated,
    output logic          miso_out,
    output logic          miso_oe,
    output logic          irq_tx,
    output logic          irq_rx
);
    ctrl_t ctrl;
    stat_t flags;
    logic  ctrl_rd_unused;

    // Control reads have no side effect in this unit.
    always_comb begin
        ctrl_rd_unused = ctrl_rd;
    end

    spi_ctrl_reg #(.DW(DW)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ctrl_wr),
        .wdata (reg_wdata),
        .ctrl  (ctrl),
        .rdata (ctrl_rdata)
    );

    spi_status_flags #(.DW(DW)) flags_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mod_en      (ctrl.mod_en),
        .stat_rd     (stat_rd),
        .ctrl_wr     (ctrl_wr),
        .data_wr     (data_wr),
        .data_rd     (data_rd),
        .tx_load_evt (tx_load_evt),
        .rx_done_evt (rx_done_evt),
        .modf_cond   (modf_cond),
        .flags       (flags),
        .rx_buf_we   (rx_buf_we),
        .rdata       (stat_rdata)
    );

    spi_irq_gen irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl   (ctrl),
        .flags  (flags),
        .irq_tx (irq_tx),
        .irq_rx (irq_rx)
    );

    spi_slave_gate gate_i (
        .ctrl          (ctrl),
        .ss_n_in       (ss_n_in),
        .sck_in        (sck_in),
        .miso_drive_in (miso_drive_in),
        .sck_gated     (sck_gated),
        .miso_out      (miso_out),
        .miso_oe       (miso_oe)
    );

endmodule

// File: rtl/spi_flag_irq_checker.sv
// Module: property checker for spi_flag_irq_unit, attached with bind.
// Observes only top-level ports.
module spi_flag_irq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_wr,
    input logic       data_rd,
    input logic [7:0] ctrl_rdata,
    input logic [7:0] stat_rdata,
    input logic       rx_done_evt,
    input logic       modf_cond,
    input logic       rx_buf_we,
    input logic       ss_n_in,
    input logic       sck_gated,
    input logic       miso_oe,
    input logic       irq_tx,
    input logic       irq_rx
);
    // Transmit request follows flag and enable one clock later.
    assert_tx_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata[0] && ctrl_rdata[2]) |=> irq_tx);

    // A completion into a full buffer must not overwrite the held byte.
    assert_keep_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_evt && stat_rdata[1] && !data_rd) |-> !rx_buf_we);

    // With receive interrupts disabled the shared line stays low.
    assert_rx_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rdata[3] && !ctrl_wr) |=> !irq_rx);

    // A rising mode-fault never coincides with a cleared module enable.
    assert_modf_keeps_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (modf_cond && ctrl_rdata[0] && !ctrl_wr) |=> (stat_rdata[3] && ctrl_rdata[0]));

    // A present fault condition keeps the flag set.
    assert_modf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (modf_cond && stat_rdata[3]) |=> stat_rdata[3]);

    // A deselected slave passes no clock and drives no data.
    assert_slave_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[0] && !ctrl_rdata[1] && ss_n_in) |-> (!sck_gated && !miso_oe));

endmodule

bind spi_flag_irq_unit spi_flag_irq_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr     (ctrl_wr),
    .data_rd     (data_rd),
    .ctrl_rdata  (ctrl_rdata),
    .stat_rdata  (stat_rdata),
    .rx_done_evt (rx_done_evt),
    .modf_cond   (modf_cond),
    .rx_buf_we   (rx_buf_we),
    .ss_n_in     (ss_n_in),
    .sck_gated   (sck_gated),
    .miso_oe     (miso_oe),
    .irq_tx      (irq_tx),
    .irq_rx      (irq_rx)
);

// File: tb/spi_flag_irq_unit_tb_top.sv
module spi_flag_irq_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       ctrl_wr = 0, ctrl_rd = 0, stat_rd = 0, data_wr = 0, data_rd = 0;
    logic [7:0] ctrl_rdata, stat_rdata;
    logic       tx_load_evt = 0, rx_done_evt = 0, modf_cond = 0;
    logic       rx_buf_we;
    logic       ss_n_in = 1, sck_in = 0, miso_drive_in = 0;
    logic       sck_gated, miso_out, miso_oe, irq_tx, irq_rx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    spi_flag_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wdata(reg_wdata),
        .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd), .stat_rd(stat_rd),
        .data_wr(data_wr), .data_rd(data_rd),
        .ctrl_rdata(ctrl_rdata), .stat_rdata(stat_rdata),
        .tx_load_evt(tx_load_evt), .rx_done_evt(rx_done_evt),
        .modf_cond(modf_cond), .rx_buf_we(rx_buf_we),
        .ss_n_in(ss_n_in), .sck_in(sck_in), .miso_drive_in(miso_drive_in),
        .sck_gated(sck_gated), .miso_out(miso_out), .miso_oe(miso_oe),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    // Vector: [15:8] control value, [7:4] setup code, [1] exp irq_tx, [0] exp irq_rx.
    // Setup bits: 4 = one completion, 5 = two completions, 6 = fault pulse, 7 = data write.
    localparam logic [15:0] VEC [12] = '{
        16'h04_02, 16'h04_80, 16'h00_00, 16'h09_11,
        16'h08_10, 16'h01_10, 16'h18_21, 16'h08_20,
        16'h10_20, 16'h39_41, 16'h19_40, 16'h29_40
    };

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp_v);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk); reg_wdata = v; ctrl_wr = 1;
        @(negedge clk); ctrl_wr = 0;
    endtask

    task automatic rd_stat();
        @(negedge clk); stat_rd = 1;
        @(negedge clk); stat_rd = 0;
    endtask

    task automatic rd_data();
        @(negedge clk); data_rd = 1;
        @(negedge clk); data_rd = 0;
    endtask

    task automatic wr_data();
        @(negedge clk); data_wr = 1;
        @(negedge clk); data_wr = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk); rx_done_evt = 1;
        @(negedge clk); rx_done_evt = 0;
    endtask

    task automatic pulse_load();
        @(negedge clk); tx_load_evt = 1;
        @(negedge clk); tx_load_evt = 0;
    endtask

    task automatic pulse_fault();
        @(negedge clk); modf_cond = 1;
        @(negedge clk); modf_cond = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check(ctrl_rdata == 8'h00, "R1 ctrl", ctrl_rdata, 8'h00);
        check(stat_rdata == 8'h01, "R1 stat", stat_rdata, 8'h01);
        check(!irq_tx && !irq_rx, "R1 irq", {irq_tx, irq_rx}, 0);

        // R2 R5 R6 R7: interrupt gating table
        for (int i = 0; i < 12; i++) begin
            logic [15:0] v;
            v = VEC[i];
            do_reset();
            wr_ctrl(v[15:8]);
            if (v[4]) pulse_done();
            if (v[5]) begin pulse_done(); pulse_done(); end
            if (v[6]) pulse_fault();
            if (v[7]) wr_data();
            tick(); tick();
            check(irq_tx == v[1], "R2 table irq_tx", irq_tx, v[1]);
            check(irq_rx == v[0], "R5/R6/R7 table irq_rx", irq_rx, v[0]);
        end

        // R12 R2: registered transmit request
        do_reset();
        wr_ctrl(8'h04);
        tick();
        wr_data();
        check(stat_rdata[0] == 0, "R2 data write clears", stat_rdata[0], 0);
        check(irq_tx == 1, "R12 irq lags clear", irq_tx, 1);
        tick();
        check(irq_tx == 0, "R12 irq follows", irq_tx, 0);
        pulse_load();
        check(stat_rdata[0] == 1 && irq_tx == 0, "R12 set lag", {stat_rdata[0], irq_tx}, 2);
        tick();
        check(irq_tx == 1, "R2 load sets irq", irq_tx, 1);

        // R3 R4: overflow keeps byte and its clear sequence
        do_reset();
        @(negedge clk); rx_done_evt = 1;
        #1 check(rx_buf_we == 1, "R3 first byte loads", rx_buf_we, 1);
        @(negedge clk); rx_done_evt = 1;
        #1 check(rx_buf_we == 0, "R3 held byte kept", rx_buf_we, 0);
        @(negedge clk); rx_done_evt = 0;
        check(stat_rdata[2:1] == 2'b11, "R3 ovr and full", stat_rdata[2:1], 3);
        rd_data();
        check(stat_rdata[2:1] == 2'b10, "R4 data read alone", stat_rdata[2:1], 2);
        rd_stat();
        rd_data();
        check(stat_rdata[2] == 0, "R4 ovr cleared", stat_rdata[2], 0);

        // R8 R9 R10: mode-fault set and clear sequence
        do_reset();
        wr_ctrl(8'h39);
        pulse_fault();
        check(stat_rdata[3] == 1, "R8 fault sets", stat_rdata[3], 1);
        check(ctrl_rdata[0] == 1, "R8 enable kept", ctrl_rdata[0], 1);
        rd_stat();
        pulse_fault();
        wr_ctrl(8'h39);
        check(stat_rdata[3] == 1, "R10 fault mid sequence", stat_rdata[3], 1);
        wr_ctrl(8'h39);
        check(stat_rdata[3] == 1, "R9 write without read", stat_rdata[3], 1);
        rd_stat();
        wr_ctrl(8'h39);
        check(stat_rdata[3] == 0, "R9 clean sequence clears", stat_rdata[3], 0);

        // R11: slave select gating
        do_reset();
        wr_ctrl(8'h01);
        ss_n_in = 1; sck_in = 1; miso_drive_in = 1;
        #1 check(!sck_gated && !miso_oe, "R11 deselected slave", {sck_gated, miso_oe}, 0);
        ss_n_in = 0;
        #1 check(sck_gated && miso_oe && miso_out, "R11 selected slave", {sck_gated, miso_oe, miso_out}, 7);
        wr_ctrl(8'h03);
        ss_n_in = 1;
        #1 check(sck_gated == 1, "R11 master keeps clock", sck_gated, 1);
        sck_in = 0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule